// File: doc/BRIEF.md
# Three-Wire Register Access Slave

This block is a serial slave that lets a host read and write a 256-entry, 8-bit register file over three wires: a serial clock, an active-low select, and one data line that carries traffic in both directions. The pad-facing side of the data line is split into an input, an output value and an output enable, so the pad can be built around it. The serial clock, select and incoming data are oversampled by the system clock. Each is passed through a two-stage synchronizer, and serial clock edges are found from the synchronized samples.

Every access is a pair of bytes framed by one low period of select. The first byte is an instruction and the second is an operand. The block keeps a persistent 8-bit address pointer. One instruction loads the pointer. Two instructions write a byte at the pointer, and two read the byte at the pointer. One of each pair of read and write instructions also advances the pointer afterwards.

On a read, the block drives the data line from falling serial clock edges during the second byte. Bit 4 of register 2 picks the drive style. In push-pull style the output is always enabled. In open-drain style the block only pulls the line low and releases it for ones.

Top module: `tw_regslave`

## Requirements
- R1: After reset every register and the address pointer are zero, and the data line is released (sd_oe low).
- R2: Bits travel MSB first. The host changes data while sclk is low and the block samples it on the rising sclk edge. A pair is 16 rising edges inside one low period of sel_n.
- R3: Instruction 0x00 loads the second byte into the address pointer.
- R4: Instruction 0x40 stores the second byte at the pointer and leaves the pointer unchanged.
- R5: Instruction 0x60 stores the second byte at the pointer, then adds one to the pointer.
- R6: Instruction 0x80 returns the byte at the pointer as the second byte and leaves the pointer unchanged. The block starts driving on the first falling sclk edge of the second byte.
- R7: Instruction 0xA0 returns the byte at the pointer, then adds one to the pointer.
- R8: Pointer increments wrap from 0xFF to 0x00.
- R9: Raising sel_n before the 16th rising edge abandons the pair. No register or pointer changes, and the next pair starts from its first bit.
- R10: The data line is released while sel_n is high.
- R11: With register 2 bit 4 set, the block only drives zeros (sd_out low whenever sd_oe is high) and releases the line for ones. With that bit clear, it drives both levels with sd_oe held high through the read byte.
- R12: Any other instruction byte makes the block ignore the second byte. The pointer and the registers stay unchanged.
- R13: Rising sclk edges after the 16th, while sel_n is still low, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host; idles high |
| sel_n | input | 1 | Active-low select that frames one byte pair |
| sd_in | input | 1 | Level seen on the data line |
| sd_out | output | 1 | Value driven onto the data line |
| sd_oe | output | 1 | Output enable for the data line |

## Verification
The bench goes after pointer arithmetic. If auto-increment were off by one or missed the wrap, a later plain read would return a neighbour's byte. It cuts pairs short both in the first byte and in the second. A slave that committed partial data, or that failed to clear its bit count, would corrupt a stored byte or misframe the next pair. Unknown instruction codes and extra clocks after the 16th bit are sent. A design that acted on them would overwrite registers or move the pointer. Each read bit is compared with the selected drive style, so a slave that drives ones in open-drain style, or releases the line in push-pull style, is reported.

// File: rtl/tw_regslave.sv
module tw_regslave #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int MODE_REG = 2,
  parameter int MODE_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sel_n,
  input  logic sd_in,
  output logic sd_out,
  output logic sd_oe
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(2 * DW + 1);
  localparam logic [CW-1:0] LAST = CW'(2 * DW - 1);
  localparam logic [CW-1:0] FIRST_END = CW'(DW - 1);
  localparam logic [CW-1:0] DONE = CW'(2 * DW);
  localparam logic [DW-1:0] OP_SET = 8'h00;
  localparam logic [DW-1:0] OP_WR  = 8'h40;
  localparam logic [DW-1:0] OP_WRI = 8'h60;
  localparam logic [DW-1:0] OP_RD  = 8'h80;
  localparam logic [DW-1:0] OP_RDI = 8'hA0;

  logic [2:0] ck_q;
  logic [1:0] sel_q, dat_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, ins, rdata;
  logic [AW-1:0] ptr;
  logic [DW-1:0] regs [DEPTH];
  logic rd_on, obit;

  wire idle = sel_q[1];
  wire rise = ck_q[1] & ~ck_q[2];
  wire fall = ~ck_q[1] & ck_q[2];
  wire [DW-1:0] word = {sh[DW-2:0], dat_q[1]};
  wire fin = ~idle & rise & (cnt == LAST);
  wire is_rd = (ins == OP_RD) | (ins == OP_RDI);
  wire known = (ins == OP_SET) | (ins == OP_WR) | (ins == OP_WRI) | is_rd;
  wire od = regs[MODE_REG][MODE_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_q  <= '1;
      sel_q <= '1;
      dat_q <= '1;
    end else begin
      ck_q  <= {ck_q[1:0], sclk};
      sel_q <= {sel_q[0], sel_n};
      dat_q <= {dat_q[0], sd_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh <= '0; ins <= '0; rdata <= '0; rd_on <= 1'b0; obit <= 1'b1;
    end else if (idle) begin
      cnt <= '0; sh <= '0; ins <= '0; rd_on <= 1'b0; obit <= 1'b1;
    end else begin
      if (rise && cnt != DONE) begin
        sh  <= word;
        cnt <= cnt + 1'b1;
        if (cnt == FIRST_END) begin
          ins   <= word;
          rdata <= regs[ptr];
        end
      end
      if (fall && is_rd && cnt > FIRST_END && cnt != DONE) begin
        rd_on <= 1'b1;
        obit  <= rdata[~cnt[2:0]];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (fin) begin
      case (ins)
        OP_SET: ptr <= word[AW-1:0];
        OP_WR:  regs[ptr] <= word;
        OP_WRI: begin regs[ptr] <= word; ptr <= ptr + 1'b1; end
        OP_RDI: ptr <= ptr + 1'b1;
        default: ;
      endcase
    end

  assign sd_oe  = rd_on & (od ? ~obit : 1'b1);
  assign sd_out = ~od & obit;

  assert_release_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) && idle |-> !sd_oe);
  assert_od_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe && od |-> !sd_out);
  assert_cnt_cap_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DONE);
  assert_ptr_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(fin));
  assert_bad_ins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !known |=> $stable(ptr));
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> cnt == '0 && !rd_on);
endmodule

// File: tb/tw_regslave_test.sv
`timescale 1ns/1ps
module tw_regslave_test;
  localparam realtime HP = 40ns;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, sel_n = 1'b1;
  logic host_oe = 1'b0, host_bit = 1'b1;
  logic sd_out, sd_oe;
  wire line = sd_oe ? sd_out : 1'b1;
  wire sd_in = host_oe ? host_bit : line;

  tw_regslave uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n),
                   .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe));

  always #2.5ns clk = ~clk;

  int checks = 0, errors = 0, oderr = 0;
  logic [7:0] got;
  logic [7:0] exp_q[$];
  string tag_q[$];
  event rd_done;
  bit od_now = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(rd_done) begin
    if (exp_q.size() == 0) chk(0, "scoreboard-empty", got, 0);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(got == e, t, got, e);
    end
  end

  task automatic pair(input logic [7:0] b0, input logic [7:0] b1, input bit rd,
                      input int nb, input int extra);
    oderr = 0;
    sel_n = 1'b0;
    #HP;
    for (int i = 0; i < nb + extra; i++) begin
      sclk = 1'b0;
      if (i < 8) begin host_oe = 1'b1; host_bit = b0[7-i]; end
      else if (i < 16 && !rd) begin host_oe = 1'b1; host_bit = b1[15-i]; end
      else if (i >= 16) begin host_oe = 1'b1; host_bit = 1'b1; end
      else host_oe = 1'b0;
      #HP;
      if (rd && i >= 8 && i < 16) begin
        got[15-i] = line;
        if (sd_oe != (od_now ? ~line : 1'b1)) oderr++;
      end
      sclk = 1'b1;
      #HP;
    end
    #HP;
    sel_n = 1'b1;
    host_oe = 1'b0;
    #(4*HP);
  endtask

  task automatic rd(input logic [7:0] ins, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    pair(ins, 8'h00, 1, 16, 0);
    ->rd_done;
    #1ns;
    chk(oderr == 0, "R11 drive style", oderr, 0);
    chk(sd_oe == 1'b0, "R10 released", sd_oe, 0);
  endtask

  task automatic cmd(input logic [7:0] ins, input logic [7:0] d);
    pair(ins, d, 0, 16, 0);
  endtask

  initial begin
    #(5ns * 200000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23ns rst_n = 1'b1;
    #20ns;
    chk(sd_oe == 1'b0, "R1 oe after reset", sd_oe, 0);
    rd(8'h80, 8'h00, "R1 reg0 after reset");
    // R3 R4 R6
    cmd(8'h00, 8'h10);
    cmd(8'h40, 8'h77);
    rd(8'h80, 8'h77, "R4 write/read");
    rd(8'h80, 8'h77, "R6 pointer kept");
    // R5 R7 R2
    cmd(8'h00, 8'h20);
    cmd(8'h60, 8'hA1);
    cmd(8'h60, 8'hB2);
    cmd(8'h60, 8'hC3);
    cmd(8'h00, 8'h20);
    rd(8'hA0, 8'hA1, "R2 msb first");
    rd(8'hA0, 8'hB2, "R7 read inc");
    rd(8'hA0, 8'hC3, "R5 write inc");
    rd(8'h80, 8'h00, "R7 pointer past block");
    // R8 wrap
    cmd(8'h00, 8'h00);
    cmd(8'h40, 8'h99);
    cmd(8'h00, 8'hFF);
    cmd(8'h60, 8'h11);
    rd(8'h80, 8'h99, "R8 write inc wrap");
    cmd(8'h00, 8'hFF);
    rd(8'hA0, 8'h11, "R8 reg ff");
    rd(8'h80, 8'h99, "R8 read inc wrap");
    // R12 unknown instructions
    cmd(8'h00, 8'h10);
    cmd(8'h41, 8'hEE);
    cmd(8'h20, 8'h55);
    rd(8'h80, 8'h77, "R12 unknown ignored");
    // R9 abort
    cmd(8'h00, 8'h30);
    cmd(8'h40, 8'h5A);
    pair(8'h40, 8'hFF, 0, 12, 0);
    rd(8'h80, 8'h5A, "R9 abort in data byte");
    pair(8'h00, 8'h00, 0, 5, 0);
    rd(8'h80, 8'h5A, "R9 abort in instruction byte");
    // R13 extra clocks
    cmd(8'h00, 8'h40);
    pair(8'h40, 8'h3C, 0, 16, 8);
    rd(8'h80, 8'h3C, "R13 extra after write");
    cmd(8'h00, 8'h41);
    cmd(8'h40, 8'h66);
    pair(8'h00, 8'h41, 0, 16, 8);
    rd(8'h80, 8'h66, "R13 extra after set");
    // R11 open-drain
    cmd(8'h00, 8'h02);
    cmd(8'h40, 8'h10);
    od_now = 1;
    rd(8'h80, 8'h10, "R11 mode reg od");
    cmd(8'h00, 8'h20);
    rd(8'hA0, 8'hA1, "R11 od data");
    cmd(8'h00, 8'h02);
    cmd(8'h40, 8'h00);
    od_now = 0;
    rd(8'h80, 8'h00, "R11 back to push-pull");
    #100ns;
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule